// File: doc/BRIEF.md
# Dual-Channel System Timer

This block is a two-channel timer attached to a simple 32-bit register bus, with one interrupt line. The first channel is a one-shot event timer. Software loads a compare value, clears the count and enables the channel. The count then rises from zero, and a match flag is raised on the clock edge at which the count reaches the compare value. The flag drives the interrupt output unless a mask bit holds it back.

The second channel is a free-running timebase counter twice as wide as the low half that software reads directly. Reading the low half also copies the upper half into a buffer. A later read of the buffer therefore returns the upper half that belongs to that same low value, even if the counter has carried into the upper half in between.

Each channel has its own divide-by-4^p prescaler, built as a count-enable pulse in the single clock domain. Each channel also has a bit in the counter-clear register and a bit in the pair of write-one-to-set / write-one-to-clear enable registers. The bus address is a word index, so a byte offset is divided by four.

Top module: `dual_timer`

## Requirements
- R1: After reset both prescale fields are 0, both channels are disabled, the flag is 0, the mask is 1, the channel-1 count, the compare value, the channel-2 count and the high buffer are 0, and irq is low. Every register reads back these values.
- R2: In the clock-control register (word 0, byte 0x00), bits [1:0] hold the channel-1 field and bits [3:2] hold the channel-2 field. A field value p makes that channel advance once every 4^p cycles (p = 3 gives 64). Counting from the edge on which the channel is enabled, the count reaches k after k·4^p cycles.
- R3: Writing 1 to bit 0 (channel 1) or bit 1 (channel 2) of enable-set (word 13, 0x34) starts that channel. Writing 1 to the same bit of enable-clear (word 14, 0x38) stops it. Bits written as 0 change nothing. A read at either word returns the enable state in bits [1:0].
- R4: Writing 1 to bit 0 of counter-clear (word 2, 0x08) zeroes the channel-1 count, and writing 1 to bit 1 zeroes the channel-2 count. Bits written as 0 have no effect. Clearing a channel also restarts its prescale phase.
- R5: The channel-1 count (word 6, 0x18, read-only, zero-extended) advances only while channel 1 is enabled and holds its value while the channel is disabled.
- R6: The match flag (word 3, bit 0) is set on the clock edge at which the channel-1 count becomes equal to the compare value (word 5, 0x14). This holds for every compare value from 4 to 2^CH1_W−1.
- R7: Writing 0 to flag bit 0 clears the flag, and writing 1 leaves it unchanged. When a match and a clear write fall on the same edge, the flag ends set.
- R8: irq is high exactly when the flag is 1 and the mask (word 4, bit 0, 0x10) is 0. A mask of 1 holds irq low and leaves the flag untouched.
- R9: The channel-2 low half is read at word 8 (0x20). Each read of it copies the upper half of the channel-2 count, as it stands at that read, into the buffer read at word 9 (0x24). No other access changes the buffer.
- R10: A clock-control write that changes a channel's field restarts that channel's prescale phase. A write that leaves the field unchanged does not disturb the phase.
- R11: busAddr is a word index. Reads of unmapped words return 0, writes to them change nothing, and no read has a side effect other than the one in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the read |
| irq | output | 1 | Channel-1 match interrupt |

## Verification
Two situations are the hardest to reach from the ports. The first is a match landing on exactly the edge where software writes 0 to the flag. The second is the channel-2 low half wrapping between a low read and the buffer read. The bench narrows the counters (12-bit compare, 8-bit halves) so that the full compare range and the carry into the upper half are reached in a few thousand cycles. It keeps its own edge counter from the enabling write and schedules each access to the exact cycle, so the clear write coincides with the match edge and the buffer read lands just past the carry.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int PS_W   = 2;

  // register word indices (byte offset / 4)
  localparam logic [ADDR_W-1:0] A_CLKCTL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CLR    = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP    = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT1   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT2LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_CNT2HI = 4'd9;
  localparam logic [ADDR_W-1:0] A_ENSET  = 4'd13;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 4'd14;

  typedef struct packed {
    logic clkCtl;
    logic cntClr;
    logic flagWr;
    logic maskWr;
    logic cmpWr;
    logic enSet;
    logic enClr;
    logic lowRd;
  } strobe_t;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler import dt_pkg::*; (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int PSC_W = 2 * ((1 << PS_W) - 1);

  logic [PSC_W-1:0] phaseQ;
  logic [PSC_W-1:0] limit;

  // limit = 4^sel - 1
  assign limit = ~({PSC_W{1'b1}} << {sel, 1'b0});
  assign tick  = run && !restart && (phaseQ == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (!run || restart || phaseQ == limit) begin
      phaseQ <= '0;
    end else begin
      phaseQ <= phaseQ + PSC_W'(1);
    end
  end
endmodule

// File: rtl/dt_ctrl.sv
module dt_ctrl import dt_pkg::*; #(
  parameter int CH1_W = 32,
  parameter int LO_W  = 32
) (
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0][PS_W-1:0] prescQ,
  input  logic [1:0]           enQ,
  input  logic                 flagQ,
  input  logic                 maskQ,
  input  logic [CH1_W-1:0]     cmpQ,
  input  logic [CH1_W-1:0]     cnt1Q,
  input  logic [LO_W-1:0]      cnt2Lo,
  input  logic [LO_W-1:0]      hiBufQ,
  output strobe_t              stb,
  output logic [DATA_W-1:0]    busRdata
);
  logic wrEn;
  logic rdEn;

  assign wrEn = busSel && busWr;
  assign rdEn = busSel && !busWr;

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (busAddr)
        A_CLKCTL: stb.clkCtl = 1'b1;
        A_CLR:    stb.cntClr = 1'b1;
        A_FLAG:   stb.flagWr = 1'b1;
        A_MASK:   stb.maskWr = 1'b1;
        A_CMP:    stb.cmpWr  = 1'b1;
        A_ENSET:  stb.enSet  = 1'b1;
        A_ENCLR:  stb.enClr  = 1'b1;
        default:  ;
      endcase
    end
    stb.lowRd = rdEn && (busAddr == A_CNT2LO);
  end

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      case (busAddr)
        A_CLKCTL:        busRdata[2*PS_W-1:0] = prescQ;
        A_FLAG:          busRdata[0]          = flagQ;
        A_MASK:          busRdata[0]          = maskQ;
        A_CMP:           busRdata[CH1_W-1:0]  = cmpQ;
        A_CNT1:          busRdata[CH1_W-1:0]  = cnt1Q;
        A_CNT2LO:        busRdata[LO_W-1:0]   = cnt2Lo;
        A_CNT2HI:        busRdata[LO_W-1:0]   = hiBufQ;
        A_ENSET, A_ENCLR: busRdata[1:0]       = enQ;
        default:         ;
      endcase
    end
  end
endmodule

// File: rtl/dt_datapath.sv
module dt_datapath import dt_pkg::*; #(
  parameter int CH1_W = 32,
  parameter int LO_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [DATA_W-1:0]    wdata,
  output logic [1:0][PS_W-1:0] prescQ,
  output logic [1:0]           enQ,
  output logic                 flagQ,
  output logic                 maskQ,
  output logic [CH1_W-1:0]     cmpQ,
  output logic [CH1_W-1:0]     cnt1Q,
  output logic [LO_W-1:0]      cnt2Lo,
  output logic [LO_W-1:0]      hiBufQ,
  output logic                 irq
);
  localparam int CH2_W = 2 * LO_W;

  logic [CH2_W-1:0] cnt2Q;
  logic [1:0]       tick;
  logic [1:0]       restart;
  logic             clr1;
  logic             clr2;
  logic [CH1_W-1:0] cnt1Nxt;
  logic             match;

  for (genvar g = 0; g < 2; g++) begin : gChan
    assign restart[g] = (stb.clkCtl && (wdata[PS_W*g +: PS_W] != prescQ[g]))
                      || (stb.cntClr && wdata[g]);
    dt_prescaler i_psc (
      .clk     (clk),
      .rstN    (rstN),
      .run     (enQ[g]),
      .restart (restart[g]),
      .sel     (prescQ[g]),
      .tick    (tick[g])
    );
  end

  assign clr1    = stb.cntClr && wdata[0];
  assign clr2    = stb.cntClr && wdata[1];
  assign cnt1Nxt = cnt1Q + CH1_W'(1);
  assign match   = tick[0] && !clr1 && (cnt1Nxt == cmpQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescQ <= '0;
      enQ    <= '0;
      maskQ  <= 1'b1;
      cmpQ   <= '0;
    end else begin
      if (stb.clkCtl) prescQ <= wdata[2*PS_W-1:0];
      if (stb.enSet)      enQ <= enQ | wdata[1:0];
      else if (stb.enClr) enQ <= enQ & ~wdata[1:0];
      if (stb.maskWr) maskQ <= wdata[0];
      if (stb.cmpWr)  cmpQ  <= wdata[CH1_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt1Q <= '0;
      flagQ <= 1'b0;
    end else begin
      if (clr1)         cnt1Q <= '0;
      else if (tick[0]) cnt1Q <= cnt1Nxt;
      if (match)                          flagQ <= 1'b1;
      else if (stb.flagWr && !wdata[0])   flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt2Q  <= '0;
      hiBufQ <= '0;
    end else begin
      if (clr2)         cnt2Q <= '0;
      else if (tick[1]) cnt2Q <= cnt2Q + CH2_W'(1);
      if (stb.lowRd) hiBufQ <= cnt2Q[CH2_W-1:LO_W];
    end
  end

  assign cnt2Lo = cnt2Q[LO_W-1:0];
  assign irq    = flagQ & ~maskQ;
endmodule

// File: rtl/dual_timer.sv
module dual_timer import dt_pkg::*; #(
  parameter int CH1_W = 32,
  parameter int LO_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  strobe_t              stb;
  logic [1:0][PS_W-1:0] prescQ;
  logic [1:0]           enQ;
  logic                 flagQ;
  logic                 maskQ;
  logic [CH1_W-1:0]     cmpQ;
  logic [CH1_W-1:0]     cnt1Q;
  logic [LO_W-1:0]      cnt2Lo;
  logic [LO_W-1:0]      hiBufQ;

  dt_ctrl #(.CH1_W(CH1_W), .LO_W(LO_W)) i_ctrl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .prescQ   (prescQ),
    .enQ      (enQ),
    .flagQ    (flagQ),
    .maskQ    (maskQ),
    .cmpQ     (cmpQ),
    .cnt1Q    (cnt1Q),
    .cnt2Lo   (cnt2Lo),
    .hiBufQ   (hiBufQ),
    .stb      (stb),
    .busRdata (busRdata)
  );

  dt_datapath #(.CH1_W(CH1_W), .LO_W(LO_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .prescQ (prescQ),
    .enQ    (enQ),
    .flagQ  (flagQ),
    .maskQ  (maskQ),
    .cmpQ   (cmpQ),
    .cnt1Q  (cnt1Q),
    .cnt2Lo (cnt2Lo),
    .hiBufQ (hiBufQ),
    .irq    (irq)
  );
endmodule

// File: rtl/dt_checker.sv
module dt_checker import dt_pkg::*; #(
  parameter int CH1_W = 32,
  parameter int LO_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        wdLow,
  input logic              irq,
  input logic [1:0]        enQ,
  input logic [CH1_W-1:0]  cnt1Q,
  input logic [CH1_W-1:0]  cmpQ,
  input logic              flagQ,
  input logic              maskQ,
  input logic [LO_W-1:0]   hiBufQ
);
  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_ENSET && wdLow[0]) |=> enQ[0]);

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_ENCLR && wdLow[1]) |=> !enQ[1]);

  // R4
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_CLR && wdLow[0]) |=> (cnt1Q == '0));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ[0] && !(busSel && busWr && busAddr == A_CLR && wdLow[0])) |=> $stable(cnt1Q));

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> (cnt1Q == cmpQ));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == A_FLAG && !wdLow[0] && !enQ[0]) |=> !flagQ);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> !irq);

  // R9
  hibuf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr && busAddr == A_CNT2LO) |=> $stable(hiBufQ));
endmodule

bind dual_timer dt_checker #(.CH1_W(CH1_W), .LO_W(LO_W)) i_dtChk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .wdLow   (busWdata[1:0]),
  .irq     (irq),
  .enQ     (enQ),
  .cnt1Q   (cnt1Q),
  .cmpQ    (cmpQ),
  .flagQ   (flagQ),
  .maskQ   (maskQ),
  .hiBufQ  (hiBufQ)
);

// File: tb/test_dual_timer.sv
module test_dual_timer;
  localparam int CH1_W = 12;
  localparam int LO_W  = 8;
  localparam logic [3:0] RA_CLK = 4'd0,  RA_CLR = 4'd2, RA_FLG = 4'd3, RA_MSK = 4'd4,
                         RA_CMP = 4'd5,  RA_CT1 = 4'd6, RA_LO  = 4'd8, RA_HI  = 4'd9,
                         RA_SET = 4'd13, RA_OFF = 4'd14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_timer #(.CH1_W(CH1_W), .LO_W(LO_W)) i_dual_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 v = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [31:0] exp, input string tag, input string what);
    logic [31:0] v;
    rd(a, v);
    chk(tag, what, v, exp);
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int e, w, d, lL, frozen;
    logic [31:0] lo, hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    rdChk(RA_CLK, 0, "R1", "clkctl");
    rdChk(RA_FLG, 0, "R1", "flag");
    rdChk(RA_MSK, 1, "R1", "mask");
    rdChk(RA_CMP, 0, "R1", "compare");
    rdChk(RA_CT1, 0, "R1", "count1");
    rdChk(RA_LO, 0, "R1", "count2 low");
    rdChk(RA_HI, 0, "R1", "high buffer");
    rdChk(RA_SET, 0, "R1", "enable");
    repeat (10) @(negedge clk);
    rdChk(RA_CT1, 0, "R1", "count1 idle");
    rdChk(RA_LO, 0, "R1", "count2 idle");

    // R11 unmapped words
    rdChk(4'd1, 0, "R11", "unmapped 1");
    rdChk(4'd7, 0, "R11", "unmapped 7");
    rdChk(4'd15, 0, "R11", "unmapped 15");
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFF);
    rdChk(RA_CLK, 0, "R11", "clkctl after unmapped write");
    rdChk(RA_MSK, 1, "R11", "mask after unmapped write");
    rdChk(RA_SET, 0, "R11", "enable after unmapped write");

    // R3 set/clear enables
    wr(RA_SET, 0);
    rdChk(RA_SET, 0, "R3", "set with zeros");
    wr(RA_SET, 2);
    rdChk(RA_OFF, 2, "R3", "ch2 started");
    wr(RA_OFF, 0);
    rdChk(RA_SET, 2, "R3", "clear with zeros");
    wr(RA_OFF, 2);
    rdChk(RA_SET, 0, "R3", "ch2 stopped");

    // R4 clear bits
    rd(RA_LO, lo);
    chk("R4", "ch2 moved", {31'b0, lo != 0}, 32'h1);
    wr(RA_CLR, 0);
    rdChk(RA_LO, lo, "R4", "zero clear write");
    wr(RA_CLR, 2);
    rdChk(RA_LO, 0, "R4", "ch2 cleared");

    // R2 R5 channel-1 prescale sweep
    for (int p = 0; p < 4; p++) begin
      lL = 1 << (2 * p);
      wr(RA_CLK, p);
      wr(RA_CLR, 1);
      wr(RA_SET, 1);
      e = cyc;
      for (int k = 1; k <= 4; k++) begin
        waitUntil(e + 2 * k * lL - 1);
        rdChk(RA_CT1, 2 * k - 1, "R2", "ch1 count before step");
        waitUntil(e + 2 * k * lL);
        rdChk(RA_CT1, 2 * k, "R2", "ch1 count at step");
      end
      wr(RA_OFF, 1);
      d = cyc;
      frozen = (d - e) / lL;
      repeat (70) @(negedge clk);
      rdChk(RA_CT1, frozen, "R5", "ch1 held while disabled");
    end
    rdChk(RA_LO, 0, "R3", "ch2 untouched by ch1 enable");

    // R2 channel-2 prescale sweep
    for (int p = 0; p < 4; p++) begin
      lL = 1 << (2 * p);
      wr(RA_CLK, p << 2);
      wr(RA_CLR, 2);
      wr(RA_SET, 2);
      e = cyc;
      for (int k = 1; k <= 3; k++) begin
        waitUntil(e + 2 * k * lL - 1);
        rdChk(RA_LO, 2 * k - 1, "R2", "ch2 count before step");
        waitUntil(e + 2 * k * lL);
        rdChk(RA_LO, 2 * k, "R2", "ch2 count at step");
      end
      wr(RA_OFF, 2);
    end

    // R10 restart on field change only
    wr(RA_CLK, 1);
    wr(RA_CLR, 1);
    wr(RA_SET, 1);
    e = cyc;
    waitUntil(e + 5);
    wr(RA_CLK, 2);
    w = cyc;
    waitUntil(w + 15);
    rdChk(RA_CT1, 1, "R10", "before restarted phase ends");
    rdChk(RA_CT1, 2, "R10", "restarted phase ends");
    waitUntil(w + 20);
    wr(RA_CLK, 6);
    waitUntil(w + 31);
    rdChk(RA_CT1, 2, "R10", "unchanged field keeps phase");
    rdChk(RA_CT1, 3, "R10", "unchanged field step");
    wr(RA_OFF, 1);
    wr(RA_CLR, 1);

    // R6 R8 R7 first match, masked
    wr(RA_CLK, 0);
    wr(RA_CMP, 4);
    rdChk(RA_CMP, 4, "R6", "compare readback");
    wr(RA_SET, 1);
    e = cyc;
    waitUntil(e + 3);
    rdChk(RA_FLG, 0, "R6", "flag before match");
    rdChk(RA_FLG, 1, "R6", "flag at match");
    chk("R8", "masked irq", {31'b0, irq}, 32'h0);
    rdChk(RA_CT1, 5, "R5", "count runs past match");
    wr(RA_MSK, 0);
    chk("R8", "unmasked irq", {31'b0, irq}, 32'h1);
    wr(RA_MSK, 1);
    chk("R8", "remasked irq", {31'b0, irq}, 32'h0);
    rdChk(RA_FLG, 1, "R8", "mask keeps flag");
    wr(RA_MSK, 0);
    wr(RA_FLG, 1);
    chk("R7", "write one keeps irq", {31'b0, irq}, 32'h1);
    rdChk(RA_FLG, 1, "R7", "write one keeps flag");
    wr(RA_FLG, 0);
    chk("R7", "write zero drops irq", {31'b0, irq}, 32'h0);
    rdChk(RA_FLG, 0, "R7", "write zero clears flag");
    wr(RA_OFF, 1);
    wr(RA_CLR, 1);

    // R6 compare sweep with irq timing
    for (int i = 0; i < 5; i++) begin
      int c, p;
      case (i)
        0: begin c = 5;    p = 0; end
        1: begin c = 17;   p = 0; end
        2: begin c = 200;  p = 0; end
        3: begin c = 4095; p = 0; end
        default: begin c = 6; p = 1; end
      endcase
      lL = 1 << (2 * p);
      wr(RA_CLK, p);
      wr(RA_CMP, c);
      wr(RA_SET, 1);
      e = cyc;
      waitUntil(e + c * lL - 1);
      chk("R6", "irq one cycle before match", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R6", "irq at match", {31'b0, irq}, 32'h1);
      wr(RA_OFF, 1);
      wr(RA_FLG, 0);
      wr(RA_CLR, 1);
      chk("R8", "irq after clear", {31'b0, irq}, 32'h0);
    end

    // R7 set wins over a coincident clear
    wr(RA_CLK, 0);
    wr(RA_CMP, 10);
    wr(RA_SET, 1);
    e = cyc;
    waitUntil(e + 9);
    wr(RA_FLG, 0);
    chk("R7", "set beats clear irq", {31'b0, irq}, 32'h1);
    rdChk(RA_FLG, 1, "R7", "set beats clear flag");
    wr(RA_OFF, 1);
    wr(RA_FLG, 0);
    wr(RA_CLR, 1);

    // R9 high buffer coherence across the low-half carry
    wr(RA_CLK, 0);
    wr(RA_CLR, 2);
    wr(RA_SET, 2);
    e = cyc;
    waitUntil(e + 255);
    rdChk(RA_LO, 255, "R9", "low just before carry");
    waitUntil(e + 258);
    rdChk(RA_HI, 0, "R9", "buffer keeps pre-carry half");
    rdChk(RA_HI, 0, "R9", "buffer unchanged by its own read");
    rd(RA_LO, lo);
    chk("R9", "low after carry", lo, (cyc - 1 - e) & 32'hFF);
    rdChk(RA_HI, 1, "R9", "buffer after low read");
    for (int j = 0; j < 5; j++) begin
      int t;
      t = e + 300 + j * 97;
      waitUntil(t);
      rd(RA_LO, lo);
      rd(RA_HI, hi);
      chk("R9", "coherent pair", (hi << 8) | lo, t - e);
    end
    wr(RA_OFF, 2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule